// File: doc/BRIEF.md
# Single-wire battery gauge bus master

This block runs transactions on a one-wire, open-drain bus of the kind used to talk to a battery fuel gauge. All bus timing comes from a slow sample tick, 20 us by default, which an internal prescaler divides down from the system clock. Every duration is a parameter counted in those ticks.

A caller starts a transaction by making its request sequence number differ from the completed sequence number that the block reports. The block then sends a break and the 8-bit command byte. If the command is a write, it also sends a data byte. If the command is a read, it releases the wire and decodes one byte from the slave's low pulses. When the transaction ends, successfully or not, the block copies the request number into the completed number and updates a 2-bit result code. Receive bits are decoded by counting how many ticks each low pulse lasts.

The pad is modelled as an output enable, an output value and a sampled input, with a pull-up outside the block. The block drives the wire only while it is transmitting. A busy flag is high whenever a transaction is in progress.

Top module: `sw_gauge_master`

## Requirements
- R1: A transaction starts on the first tick where `req_seq` differs from `done_seq`, compared by inequality so that the counters may wrap. At the end of a transaction, success or error, `done_seq` takes the value of `req_seq` and `result` is updated.
- R2: A transaction opens with the wire driven low for T_BRK_LO ticks and then driven high for T_BRK_HI ticks.
- R3: Each transmitted bit is a cell of T_CELL ticks, sent least significant bit first. The wire is driven low for T_ONE_LO ticks for a 1 or T_ZERO_LO ticks for a 0, and driven high for the rest of the cell.
- R4: When command bit 7 is 1 (write), the wire stays driven high for an extra T_TX_GAP ticks after the command's last cell. The data byte then follows in the same cell format, after which the wire is released and `result` is 0.
- R5: When command bit 7 is 0 (read), the wire is released after the command. If more than T_RX_WAIT consecutive ticks sample the wire high before the slave pulls it low, the transaction ends with `result` = 1.
- R6: A received bit whose low pulse lasts at most T_ONE_MAX samples decodes as 1, and a longer pulse decodes as 0. The first received bit lands in `rd_data` bit 0 and the eighth in bit 7. After eight bits, `result` is 0.
- R7: A low pulse of more than T_RX_FIRST samples on the first received bit, or more than T_RX_LATER samples on any later bit, ends the transaction with `result` = 2.
- R8: More than T_RX_GAP consecutive high samples between two received bits ends the transaction with `result` = 3.
- R9: After reset, and whenever no transaction is in progress, `busy` and `pad_oe` are 0. `busy` is 1 for the whole of a transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_seq | input | SEQ_W | Request number; a new transaction is requested when it differs from done_seq |
| cmd_byte | input | 8 | Command byte, bit 7 selects write (1) or read (0) |
| wr_byte | input | 8 | Payload byte for writes |
| pad_in | input | 1 | Sampled level of the bus wire |
| pad_oe | output | 1 | Drive enable for the bus wire |
| pad_out | output | 1 | Driven level when pad_oe is 1 |
| busy | output | 1 | Transaction in progress |
| done_seq | output | SEQ_W | Number of the last completed request |
| rd_data | output | 8 | Byte received by a read |
| result | output | 2 | 0 ok, 1 no response, 2 low pulse too long, 3 gap too long |

## Verification
The bench builds the block with CLK_PER_TICK = 4 and a 4-bit sequence number, and keeps the default tick counts. Four clocks per tick make each timeout window, including the 150-tick response wait, only a few hundred cycles long. This lets every limit be exercised exactly at its boundary and one tick past it. The short sequence number wraps several times during the run, and transmitted pulse widths are checked in whole clock cycles against tick multiples.

// File: rtl/swg_pkg.sv
package swg_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_BRK, S_BREC, S_TLO, S_THI, S_TGAP, S_RWAIT, S_RLO, S_RHI
  } swg_state_e;

  typedef enum logic [1:0] {
    R_OK = 2'd0, R_NORESP = 2'd1, R_LONGLOW = 2'd2, R_LONGGAP = 2'd3
  } swg_result_e;

  // ticks the line is held low for one transmitted bit
  function automatic int tx_low_ticks(logic b, int one_lo, int zero_lo);
    return b ? one_lo : zero_lo;
  endfunction

  // bit value recovered from a low pulse measured in samples
  function automatic logic rx_decode(int width, int one_max);
    return (width <= one_max);
  endfunction

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/swg_tick_gen.sv
module swg_tick_gen #(
  parameter int DIV = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = $clog2(DIV + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (cnt == CW'(DIV - 1)) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == CW'(DIV - 1));

  // R1
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (DIV > 1 && tick) |=> !tick);
endmodule

// File: rtl/swg_phase_timer.sv
module swg_phase_timer #(
  parameter int TW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expire
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (load) cnt <= load_val;
    else if (tick && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expire = tick && (cnt == TW'(1));

  // R3
  timer_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !load) |=> (cnt == '0));
endmodule

// File: rtl/sw_gauge_master.sv
module sw_gauge_master #(
  parameter int CLK_PER_TICK = 1000,
  parameter int SEQ_W        = 4,
  parameter int T_BRK_LO     = 10,
  parameter int T_BRK_HI     = 3,
  parameter int T_CELL       = 10,
  parameter int T_ONE_LO     = 2,
  parameter int T_ZERO_LO    = 6,
  parameter int T_TX_GAP     = 15,
  parameter int T_RX_WAIT    = 150,
  parameter int T_RX_FIRST   = 15,
  parameter int T_RX_LATER   = 50,
  parameter int T_RX_GAP     = 20,
  parameter int T_ONE_MAX    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEQ_W-1:0] req_seq,
  input  logic [7:0]       cmd_byte,
  input  logic [7:0]       wr_byte,
  input  logic             pad_in,
  output logic             pad_oe,
  output logic             pad_out,
  output logic             busy,
  output logic [SEQ_W-1:0] done_seq,
  output logic [7:0]       rd_data,
  output logic [1:0]       result
);
  import swg_pkg::*;

  localparam int TMAX = max3(max3(T_BRK_LO, T_BRK_HI, T_CELL), T_TX_GAP, 1);
  localparam int TW   = $clog2(TMAX + 1);
  localparam int MMAX = max3(T_RX_WAIT, max3(T_RX_FIRST, T_RX_LATER, 1), T_RX_GAP);
  localparam int MW   = $clog2(MMAX + 2);

  swg_state_e    st;
  logic [7:0]    cmd_q, wr_q, sh_q, rd_q;
  logic [2:0]    bit_q;
  logic          data_phase;
  logic [MW-1:0] meas;
  logic [SEQ_W-1:0] done_q;
  logic [1:0]    res_q;
  logic          sync1, line_s;

  logic          tick, tmr_load, tmr_exp;
  logic [TW-1:0] tmr_val;

  // named events used by the FSM and the assertions
  logic          start_w, cell_end_w, byte_end_w, rx_rise_w;
  logic [MW-1:0] rx_limit_w;

  swg_tick_gen #(.DIV(CLK_PER_TICK)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick));

  swg_phase_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(tmr_load),
    .load_val(tmr_val), .expire(tmr_exp));

  // two-flop synchroniser on the wire input
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1  <= 1'b1;
      line_s <= 1'b1;
    end else begin
      sync1  <= pad_in;
      line_s <= sync1;
    end
  end

  assign start_w    = tick && (st == S_IDLE) && (req_seq != done_q);
  assign cell_end_w = tmr_exp && (st == S_THI);
  assign byte_end_w = cell_end_w && (bit_q == 3'd7);
  assign rx_rise_w  = tick && (st == S_RLO) && line_s;
  assign rx_limit_w = (bit_q == 3'd0) ? MW'(T_RX_FIRST) : MW'(T_RX_LATER);

  // timer reload on every timed-phase entry
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (start_w) begin
      tmr_load = 1'b1;
      tmr_val  = TW'(T_BRK_LO);
    end else if (tmr_exp) begin
      case (st)
        S_BRK:  begin tmr_load = 1'b1; tmr_val = TW'(T_BRK_HI); end
        S_BREC: begin
          tmr_load = 1'b1;
          tmr_val  = TW'(tx_low_ticks(cmd_q[0], T_ONE_LO, T_ZERO_LO));
        end
        S_TLO: begin
          tmr_load = 1'b1;
          tmr_val  = TW'(T_CELL - tx_low_ticks(sh_q[0], T_ONE_LO, T_ZERO_LO));
        end
        S_THI: begin
          if (bit_q != 3'd7) begin
            tmr_load = 1'b1;
            tmr_val  = TW'(tx_low_ticks(sh_q[1], T_ONE_LO, T_ZERO_LO));
          end else if (!data_phase && cmd_q[7]) begin
            tmr_load = 1'b1;
            tmr_val  = TW'(T_TX_GAP);
          end
        end
        S_TGAP: begin
          tmr_load = 1'b1;
          tmr_val  = TW'(tx_low_ticks(wr_q[0], T_ONE_LO, T_ZERO_LO));
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cmd_q      <= '0;
      wr_q       <= '0;
      sh_q       <= '0;
      rd_q       <= '0;
      bit_q      <= '0;
      data_phase <= 1'b0;
      meas       <= '0;
      done_q     <= '0;
      res_q      <= R_OK;
    end else if (tick) begin
      case (st)
        S_IDLE: if (start_w) begin
          st         <= S_BRK;
          cmd_q      <= cmd_byte;
          wr_q       <= wr_byte;
          data_phase <= 1'b0;
          rd_q       <= '0;
        end
        S_BRK:  if (tmr_exp) st <= S_BREC;
        S_BREC: if (tmr_exp) begin
          st    <= S_TLO;
          sh_q  <= cmd_q;
          bit_q <= '0;
        end
        S_TLO:  if (tmr_exp) st <= S_THI;
        S_THI:  if (tmr_exp) begin
          if (!byte_end_w) begin
            sh_q  <= sh_q >> 1;
            bit_q <= bit_q + 3'd1;
            st    <= S_TLO;
          end else if (data_phase) begin
            st     <= S_IDLE;
            done_q <= req_seq;
            res_q  <= R_OK;
          end else if (cmd_q[7]) begin
            st <= S_TGAP;
          end else begin
            st    <= S_RWAIT;
            meas  <= '0;
            bit_q <= '0;
          end
        end
        S_TGAP: if (tmr_exp) begin
          st         <= S_TLO;
          sh_q       <= wr_q;
          bit_q      <= '0;
          data_phase <= 1'b1;
        end
        S_RWAIT: begin
          if (!line_s) begin
            st   <= S_RLO;
            meas <= MW'(1);
          end else if (meas == MW'(T_RX_WAIT)) begin
            st     <= S_IDLE;
            done_q <= req_seq;
            res_q  <= R_NORESP;
          end else meas <= meas + 1'b1;
        end
        S_RLO: begin
          if (rx_rise_w) begin
            rd_q <= {rx_decode(int'(meas), T_ONE_MAX), rd_q[7:1]};
            if (bit_q == 3'd7) begin
              st     <= S_IDLE;
              done_q <= req_seq;
              res_q  <= R_OK;
            end else begin
              bit_q <= bit_q + 3'd1;
              st    <= S_RHI;
              meas  <= MW'(1);
            end
          end else if (meas == rx_limit_w) begin
            st     <= S_IDLE;
            done_q <= req_seq;
            res_q  <= R_LONGLOW;
          end else meas <= meas + 1'b1;
        end
        S_RHI: begin
          if (!line_s) begin
            st   <= S_RLO;
            meas <= MW'(1);
          end else if (meas == MW'(T_RX_GAP)) begin
            st     <= S_IDLE;
            done_q <= req_seq;
            res_q  <= R_LONGGAP;
          end else meas <= meas + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy     = (st != S_IDLE);
  assign pad_oe   = (st == S_BRK) || (st == S_BREC) || (st == S_TLO) ||
                    (st == S_THI) || (st == S_TGAP);
  assign pad_out  = !((st == S_BRK) || (st == S_TLO));
  assign done_seq = done_q;
  assign rd_data  = rd_q;
  assign result   = res_q;

  // R9
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !pad_oe);

  // R1
  seq_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_seq != $past(done_seq)) |-> (!busy && $past(busy)));

  // R3
  pad_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> ($stable(pad_oe) && $stable(pad_out)));

  // R7
  low_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RLO) |-> (meas <= rx_limit_w));

  // R8
  gap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RHI) |-> (meas <= MW'(T_RX_GAP)));

  // R5
  rx_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RWAIT || st == S_RLO || st == S_RHI) |-> !pad_oe);
endmodule

// File: tb/sim_sw_gauge_master.sv
module sim_sw_gauge_master;
  localparam int DIV = 4, SW = 4;
  localparam int BLO = 10, BHI = 3, CELL = 10, ONE = 2, ZERO = 6, GAP = 15;
  localparam int RW = 150, RF = 15, RL = 50, RG = 20, OMAX = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [SW-1:0] req_seq = '0;
  logic [7:0] cmd_b = '0, wr_b = '0;
  logic slave_low = 1'b0;
  wire pad_oe, pad_out, pad_in, busy;
  wire [SW-1:0] done_seq;
  wire [7:0] rd_data;
  wire [1:0] result;

  assign pad_in = (pad_oe ? pad_out : 1'b1) & ~slave_low;

  sw_gauge_master #(.CLK_PER_TICK(DIV), .SEQ_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_seq(req_seq), .cmd_byte(cmd_b),
    .wr_byte(wr_b), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .busy(busy), .done_seq(done_seq), .rd_data(rd_data), .result(result));

  int n_chk = 0, n_fail = 0;
  int lo_w[40], hi_w[40];
  int n_lo = 0, n_hi = 0, lo_run = 0, hi_run = 0;
  bit busy_seen = 0;
  int s_wait;
  int s_lo[8], s_hi[8];

  task automatic check(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // pulse-width monitor of what the master drives, in clock cycles
  always @(negedge clk) begin
    if (busy) busy_seen = 1;
    if (pad_oe && !pad_out) lo_run++;
    else if (lo_run > 0) begin
      if (n_lo < 40) lo_w[n_lo] = lo_run;
      n_lo++;
      lo_run = 0;
    end
    if (pad_oe && pad_out) hi_run++;
    else if (hi_run > 0) begin
      if (n_hi < 40) hi_w[n_hi] = hi_run;
      n_hi++;
      hi_run = 0;
    end
  end

  function automatic int lo_of(logic b);
    return (b ? ONE : ZERO);
  endfunction

  // expected outcome of a read from the scripted slave, per R5..R8
  function automatic void exp_read(output int e, output logic [7:0] d);
    d = '0;
    e = 0;
    if (s_wait > RW) begin e = 1; return; end
    for (int i = 0; i < 8; i++) begin
      if (s_lo[i] > ((i == 0) ? RF : RL)) begin e = 2; return; end
      d[i] = (s_lo[i] <= OMAX);
      if (i == 7) return;
      if (s_hi[i] > RG) begin e = 3; return; end
    end
  endfunction

  task automatic slave_run();
    bit seen = 0;
    while (1) begin
      @(negedge clk);
      if (pad_oe) seen = 1;
      else if (seen) break;
    end
    repeat (s_wait * DIV) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      slave_low = 1'b1;
      repeat (s_lo[i] * DIV) @(negedge clk);
      slave_low = 1'b0;
      repeat (s_hi[i] * DIV) @(negedge clk);
    end
  endtask

  task automatic run_txn(input logic [7:0] cmd, input logic [7:0] wd);
    int exp_lo[17], exp_hi[17];
    int nexp, bad, e;
    logic [7:0] ed;
    @(posedge clk);
    n_lo = 0; n_hi = 0; lo_run = 0; hi_run = 0; busy_seen = 0;
    @(negedge clk);
    cmd_b = cmd;
    wr_b = wd;
    req_seq = req_seq + 1'b1;
    fork
      begin
        while (done_seq != req_seq) @(negedge clk);
      end
      begin
        if (!cmd[7]) slave_run();
      end
    join
    repeat (3) @(negedge clk);

    // expected master waveform in clock cycles
    exp_lo[0] = BLO * DIV;
    exp_hi[0] = BHI * DIV;
    for (int i = 0; i < 8; i++) begin
      exp_lo[1 + i] = lo_of(cmd[i]) * DIV;
      exp_hi[1 + i] = (CELL - lo_of(cmd[i])) * DIV;
    end
    nexp = 9;
    if (cmd[7]) begin
      exp_hi[8] += GAP * DIV;
      for (int i = 0; i < 8; i++) begin
        exp_lo[9 + i] = lo_of(wd[i]) * DIV;
        exp_hi[9 + i] = (CELL - lo_of(wd[i])) * DIV;
      end
      nexp = 17;
    end
    // R2 break low and recovery high
    check("R2", lo_w[0], exp_lo[0], "break low cycles");
    check("R2", hi_w[0], exp_hi[0], "break recovery cycles");
    // R3 / R4 pulse train
    check("R3", n_lo, nexp, "driven low pulse count");
    check("R3", n_hi, nexp, "driven high run count");
    bad = -1;
    for (int i = 1; i < nexp; i++)
      if (bad < 0 && (lo_w[i] != exp_lo[i] || hi_w[i] != exp_hi[i])) bad = i;
    if (bad >= 0)
      check(cmd[7] ? "R4" : "R3", lo_w[bad] * 1000 + hi_w[bad],
            exp_lo[bad] * 1000 + exp_hi[bad], "cell low*1000+high");
    else
      check(cmd[7] ? "R4" : "R3", 0, 0, "cell train");
    // R1 completion
    check("R1", int'(done_seq), int'(req_seq), "done_seq");
    // R9
    check("R9", int'(busy_seen), 1, "busy during transaction");
    check("R9", int'({busy, pad_oe}), 0, "busy/pad_oe after end");
    if (cmd[7]) begin
      check("R4", int'(result), 0, "write result");
    end else begin
      exp_read(e, ed);
      case (e)
        0: begin
          check("R6", int'(result), 0, "read result");
          check("R6", int'(rd_data), int'(ed), "read data");
        end
        1: check("R5", int'(result), 1, "no-response result");
        2: check("R7", int'(result), 2, "long-low result");
        default: check("R8", int'(result), 3, "long-gap result");
      endcase
    end
  endtask

  task automatic script_plain(input logic [7:0] v);
    s_wait = 5;
    for (int i = 0; i < 8; i++) begin
      s_lo[i] = v[i] ? 2 : 6;
      s_hi[i] = 4;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9", int'({busy, pad_oe}), 0, "busy/pad_oe after reset");
    check("R1", int'(done_seq), 0, "done_seq after reset");
    check("R5", int'(result), 0, "result after reset");

    // directed writes, R4
    run_txn(8'hA5, 8'h3C);
    run_txn(8'hFF, 8'h00);
    run_txn(8'h80, 8'hFF);

    // directed reads, R6 decode boundary
    script_plain(8'h5A);
    run_txn(8'h21, 8'h00);
    script_plain(8'h00);
    s_lo[0] = OMAX;     // decodes 1
    s_lo[1] = OMAX + 1; // decodes 0
    s_lo[2] = 1;
    run_txn(8'h0E, 8'h00);
    // R7 first-bit limit
    script_plain(8'hC3); s_lo[0] = RF;     run_txn(8'h01, 8'h00);
    script_plain(8'hC3); s_lo[0] = RF + 1; run_txn(8'h01, 8'h00);
    // R7 later-bit limit
    script_plain(8'h81); s_lo[4] = RL;     run_txn(8'h02, 8'h00);
    script_plain(8'h81); s_lo[4] = RL + 1; run_txn(8'h02, 8'h00);
    // R8 gap limit
    script_plain(8'h18); s_hi[2] = RG;     run_txn(8'h03, 8'h00);
    script_plain(8'h18); s_hi[2] = RG + 1; run_txn(8'h03, 8'h00);
    // R5 response wait limit
    script_plain(8'h66); s_wait = RW;      run_txn(8'h04, 8'h00);
    script_plain(8'h66); s_wait = RW + 1;  run_txn(8'h04, 8'h00);
    script_plain(8'h99); s_wait = 0;       run_txn(8'h05, 8'h00);

    // constrained random mix; sequence number wraps (R1)
    for (int t = 0; t < 24; t++) begin
      logic [7:0] c, d;
      c = 8'($urandom);
      d = 8'($urandom);
      s_wait = int'($urandom % 21);
      for (int i = 0; i < 8; i++) begin
        s_lo[i] = 1 + int'($urandom % 8);
        s_hi[i] = 1 + int'($urandom % 6);
      end
      run_txn(c, d);
    end

    summary();
    $finish;
  end
endmodule